// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable behavioural model of a synchronous static RAM whose read and write data phases sit the same number of cycles after their commands. Because the two delays match, a read can follow a write, and a write can follow a read, on consecutive cycles without any idle cycle on the shared data bus. Address, byte-lane write enables, write enable, the three chip selects and the load/continue control are all registered on the rising clock edge. A small internal array holds the data, organised as independent 9-bit byte lanes.

Two latency settings are supported through a static mode input. In registered-output mode, read data leaves through an output register and write data is taken two enabled edges after its command. In flow-through mode both delays are one cycle shorter. A clock-enable input stalls the whole model. An asynchronous output-enable input can turn the data drivers off at any time. The bus is modelled as separate input data, output data and drive-enable ports, so the surrounding logic builds the tri-state pad.

A read that reaches an address whose write data has not yet been committed returns the pending data, merged lane by lane. The model therefore always presents the result of commands in the order in which they were issued.

Top module: `zt_sram`

## Requirements
- R1: With ft_mode_i low, a read registered on enabled edge N drives dq_oe_o high and the stored word on dq_o from enabled edge N+1 until the next enabled edge.
- R2: With ft_mode_i high, a read registered on enabled edge N drives its word from edge N onward, until the next enabled edge.
- R3: A write registered on enabled edge N takes dq_i at enabled edge N+2 with ft_mode_i low, or at N+1 with ft_mode_i high.
- R4: A load cycle (burst_cont_i low) selects the device only when sel0_n_i=0, sel1_i=1 and sel2_n_i=0. With any one of them inactive, the cycle is a deselect: nothing is written and the bus is not driven in its data slot.
- R5: With burst_cont_i high, the previous operation type repeats at an address whose low 2 bits are incremented modulo 4, with the upper bits kept. The chip selects, wr_n_i and addr_i are ignored, and a continue after a deselect stays deselected.
- R6: Bit i of lane_wr_n_i (active low) guards lane i, which is bits [9i+8:9i] of the word. A write with every lane bit high is an abort and leaves memory unchanged.
- R7: With clk_en_n_i high, an edge has no effect. A read data phase in progress stays driven and holds its value, and the write and read latencies count enabled edges only.
- R8: out_en_n_i high forces dq_oe_o low at once, without waiting for a clock edge.
- R9: dq_oe_o is low in every write data phase, including aborted writes.
- R10: A read of an address with a write still in the late-write pipeline returns that write's data in its enabled lanes and the older contents in the others.
- R11: During and right after reset, dq_oe_o is low and no write is pending.
- R12: Read, write, read on consecutive cycles completes without idle cycles and with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ft_mode_i | input | 1 | 1 = flow-through latency, 0 = registered output; change only in reset |
| clk_en_n_i | input | 1 | Clock enable, active low; high stalls the model |
| sel0_n_i | input | 1 | Chip select, active low |
| sel1_i | input | 1 | Chip select, active high |
| sel2_n_i | input | 1 | Chip select, active low |
| burst_cont_i | input | 1 | 1 = continue burst, 0 = load new command |
| wr_n_i | input | 1 | 0 = write, 1 = read on a load cycle |
| lane_wr_n_i | input | NL | Per-lane write enables, active low |
| addr_i | input | AW | Word address |
| out_en_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | NL*LW | Write data from the bus |
| dq_o | output | NL*LW | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is a read that arrives while one or two writes to the same word are still waiting for their late data, with only some lanes enabled. In that case the answer must be assembled from the array and the bus in the same cycle. The stimulus writes one address in full, then issues partial-lane writes to it back to back and follows them at once with a read, in both latency modes. A reference model applies every command in issue order, so the expected word already includes the pending writes. Stall cycles are placed inside read and write data phases, so that latency counted in enabled edges can be told apart from latency counted in raw clock edges.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_cmd_stage.sv
`timescale 1ns/1ps
module zt_cmd_stage
  import zt_sram_pkg::*;
#(
  parameter int AW      = 6,
  parameter int NL      = 2,
  parameter int BURST_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          sel0_n_i,
  input  logic          sel1_i,
  input  logic          sel2_n_i,
  input  logic          burst_cont_i,
  input  logic          wr_n_i,
  input  logic [NL-1:0] lane_wr_n_i,
  input  logic [AW-1:0] addr_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic [NL-1:0] lane_wr_n_o
);
  logic          sel_all;
  op_e           op_d;
  logic [AW-1:0] addr_d;
  logic [BURST_W-1:0] cnt_nxt;

  assign sel_all = !sel0_n_i && sel1_i && !sel2_n_i;
  assign cnt_nxt = addr_o[BURST_W-1:0] + BURST_W'(1);

  always_comb begin
    if (burst_cont_i) begin
      op_d   = op_o;
      addr_d = {addr_o[AW-1:BURST_W], cnt_nxt};
    end else begin
      op_d   = !sel_all ? OP_IDLE : (wr_n_i ? OP_READ : OP_WRITE);
      addr_d = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o        <= OP_IDLE;
      addr_o      <= '0;
      lane_wr_n_o <= '1;
    end else if (en_i) begin
      op_o        <= op_d;
      addr_o      <= addr_d;
      lane_wr_n_o <= lane_wr_n_i;
    end
  end

  a_r4_deselect_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !burst_cont_i && !sel_all) |=> (op_o == OP_IDLE));

  a_r5_cont_keeps_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && burst_cont_i) |=> (op_o == $past(op_o)));

  a_r5_cont_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && burst_cont_i) |=>
      (addr_o[BURST_W-1:0] == $past(addr_o[BURST_W-1:0]) + BURST_W'(1)));
endmodule

// File: rtl/zt_wr_pipe.sv
`timescale 1ns/1ps
module zt_wr_pipe
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   ft_i,
  input  op_e                    op1_i,
  input  logic [AW-1:0]          addr1_i,
  input  logic [NL-1:0]          lane_wr_n1_i,
  input  logic [NL-1:0][LW-1:0]  dq_i,
  output logic                   wr_slot_o,
  output logic [NL-1:0]          lane_we_o,
  output logic [AW-1:0]          waddr_o,
  output logic [NL-1:0][LW-1:0]  wdata_o
);
  op_e           op2_q;
  logic [AW-1:0] addr2_q;
  logic [NL-1:0] lane_wr_n2_q;
  logic [NL-1:0] bw_n_c;

  // second late-write stage, used only with the registered-output latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op2_q        <= OP_IDLE;
      addr2_q      <= '0;
      lane_wr_n2_q <= '1;
    end else if (en_i) begin
      op2_q        <= op1_i;
      addr2_q      <= addr1_i;
      lane_wr_n2_q <= lane_wr_n1_i;
    end
  end

  assign wr_slot_o = ft_i ? (op1_i == OP_WRITE) : (op2_q == OP_WRITE);
  assign waddr_o   = ft_i ? addr1_i : addr2_q;
  assign bw_n_c    = ft_i ? lane_wr_n1_i : lane_wr_n2_q;
  assign lane_we_o = {NL{en_i & wr_slot_o}} & ~bw_n_c;
  assign wdata_o   = dq_i;
endmodule

// File: rtl/zt_mem_array.sv
`timescale 1ns/1ps
module zt_mem_array #(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 9
) (
  input  logic                  clk_i,
  input  logic [NL-1:0]         lane_we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [NL-1:0][LW-1:0] wdata_i,
  input  logic [AW-1:0]         raddr_i,
  output logic [NL-1:0][LW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_we_i[l]) store[waddr_i] <= wdata_i[l];
    end

    assign rdata_o[l] = store[raddr_i];
  end
endmodule

// File: rtl/zt_rd_path.sv
`timescale 1ns/1ps
module zt_rd_path
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  ft_i,
  input  op_e                   op1_i,
  input  logic [AW-1:0]         addr1_i,
  input  logic [NL-1:0][LW-1:0] mem_rdata_i,
  input  logic [NL-1:0]         lane_we_i,
  input  logic [AW-1:0]         waddr_i,
  input  logic [NL-1:0][LW-1:0] wdata_i,
  input  logic                  out_en_n_i,
  output logic [NL-1:0][LW-1:0] dq_o,
  output logic                  dq_oe_o
);
  logic [NL-1:0][LW-1:0] merged;
  logic [NL-1:0][LW-1:0] out_q;
  logic                  vld_q;
  logic                  drive;

  // forward the write whose data is on the bus this cycle, per lane
  always_comb begin
    merged = mem_rdata_i;
    for (int l = 0; l < NL; l++) begin
      if (lane_we_i[l] && (waddr_i == addr1_i)) merged[l] = wdata_i[l];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      out_q <= '0;
    end else if (en_i) begin
      vld_q <= (op1_i == OP_READ);
      if (op1_i == OP_READ) out_q <= merged;
    end
  end

  assign drive   = ft_i ? (op1_i == OP_READ) : vld_q;
  assign dq_o    = ft_i ? merged : out_q;
  assign dq_oe_o = drive & ~out_en_n_i;

  a_r7_stall_holds_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && drive) |=> (drive && $stable(dq_o)));
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NL = 2,
  parameter int LW = 9,
  localparam int DW = NL * LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ft_mode_i,
  input  logic          clk_en_n_i,
  input  logic          sel0_n_i,
  input  logic          sel1_i,
  input  logic          sel2_n_i,
  input  logic          burst_cont_i,
  input  logic          wr_n_i,
  input  logic [NL-1:0] lane_wr_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic          out_en_n_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic                  en;
  op_e                   op1;
  logic [AW-1:0]         addr1;
  logic [NL-1:0]         bw_n1;
  logic                  wr_slot;
  logic [NL-1:0]         lane_we;
  logic [AW-1:0]         waddr;
  logic [NL-1:0][LW-1:0] wdata;
  logic [NL-1:0][LW-1:0] rdata;
  logic [NL-1:0][LW-1:0] dq_lanes;

  assign en = ~clk_en_n_i;

  zt_cmd_stage #(.AW(AW), .NL(NL)) u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .sel0_n_i     (sel0_n_i),
    .sel1_i       (sel1_i),
    .sel2_n_i     (sel2_n_i),
    .burst_cont_i (burst_cont_i),
    .wr_n_i       (wr_n_i),
    .lane_wr_n_i  (lane_wr_n_i),
    .addr_i       (addr_i),
    .op_o         (op1),
    .addr_o       (addr1),
    .lane_wr_n_o  (bw_n1)
  );

  zt_wr_pipe #(.AW(AW), .NL(NL), .LW(LW)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .ft_i         (ft_mode_i),
    .op1_i        (op1),
    .addr1_i      (addr1),
    .lane_wr_n1_i (bw_n1),
    .dq_i         (dq_i),
    .wr_slot_o    (wr_slot),
    .lane_we_o    (lane_we),
    .waddr_o      (waddr),
    .wdata_o      (wdata)
  );

  zt_mem_array #(.AW(AW), .NL(NL), .LW(LW)) u_mem (
    .clk_i     (clk_i),
    .lane_we_i (lane_we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_i   (addr1),
    .rdata_o   (rdata)
  );

  zt_rd_path #(.AW(AW), .NL(NL), .LW(LW)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en),
    .ft_i        (ft_mode_i),
    .op1_i       (op1),
    .addr1_i     (addr1),
    .mem_rdata_i (rdata),
    .lane_we_i   (lane_we),
    .waddr_i     (waddr),
    .wdata_i     (wdata),
    .out_en_n_i  (out_en_n_i),
    .dq_o        (dq_lanes),
    .dq_oe_o     (dq_oe_o)
  );

  assign dq_o = dq_lanes;

  a_r9_no_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_slot |-> !dq_oe_o);
endmodule

// File: tb/sim_zt_sram.sv
`timescale 1ns/1ps
module sim_zt_sram;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ft_mode_i = 1'b0;
  logic          clk_en_n_i = 1'b1;
  logic          sel0_n_i = 1'b1;
  logic          sel1_i = 1'b0;
  logic          sel2_n_i = 1'b1;
  logic          burst_cont_i = 1'b0;
  logic          wr_n_i = 1'b1;
  logic [NL-1:0] lane_wr_n_i = '1;
  logic [AW-1:0] addr_i = '0;
  logic          out_en_n_i = 1'b0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  always #2.5 clk = ~clk;

  zt_sram #(.AW(AW), .NL(NL), .LW(LW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ft_mode_i(ft_mode_i), .clk_en_n_i(clk_en_n_i),
    .sel0_n_i(sel0_n_i), .sel1_i(sel1_i), .sel2_n_i(sel2_n_i),
    .burst_cont_i(burst_cont_i), .wr_n_i(wr_n_i), .lane_wr_n_i(lane_wr_n_i),
    .addr_i(addr_i), .out_en_n_i(out_en_n_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int en_cnt = 0;
  bit ft = 1'b0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  int last_op = 0;  // 0 idle, 1 read, 2 write
  logic [AW-1:0] last_addr = '0;

  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] wsched [int];
  int            exp_slot_q [$];
  logic [DW-1:0] exp_data_q [$];
  string         exp_tag_q [$];

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (ft=%0d slot=%0d)", tag, act, exp, ft, en_cnt);
    end
  endtask

  // scoreboard monitor: samples 1 ns before each rising edge
  initial forever begin
    @(negedge clk);
    #1.5;
    if (mon_on) begin
      while (exp_slot_q.size() > 0 && exp_slot_q[0] < en_cnt) begin
        void'(exp_slot_q.pop_front());
        void'(exp_data_q.pop_front());
        void'(exp_tag_q.pop_front());
      end
      if (exp_slot_q.size() > 0 && exp_slot_q[0] == en_cnt) begin
        if (out_en_n_i)
          check(dq_oe_o === 1'b0, "R8 output enable forces off", DW'(dq_oe_o), '0);
        else
          check(dq_oe_o === 1'b1 && dq_o === exp_data_q[0], exp_tag_q[0],
                dq_oe_o ? dq_o : 'x, exp_data_q[0]);
      end else begin
        check(dq_oe_o === 1'b0, "R9 R4 bus released outside read slots", DW'(dq_oe_o), '0);
      end
    end
  end

  // one clock cycle of stimulus; off selects which chip select is inactive (0 = none)
  task automatic cyc(input bit stall, input bit cont, input int off, input bit wr_n,
                     input logic [NL-1:0] bw, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit oe_n, input string tag);
    int op;
    logic [AW-1:0] ea;
    @(negedge clk);
    clk_en_n_i   = stall;
    burst_cont_i = cont;
    sel0_n_i     = (off == 1);
    sel1_i       = (off != 2);
    sel2_n_i     = (off == 3);
    wr_n_i       = wr_n;
    lane_wr_n_i  = bw;
    addr_i       = a;
    out_en_n_i   = oe_n;
    dq_i         = wsched.exists(en_cnt) ? wsched[en_cnt] : '1;
    if (!stall) begin
      if (cont) begin
        op = last_op;
        ea = {last_addr[AW-1:2], last_addr[1:0] + 2'd1};
      end else begin
        op = (off != 0) ? 0 : (wr_n ? 1 : 2);
        ea = a;
      end
      if (op == 1) begin
        exp_slot_q.push_back(en_cnt + 1 + (ft ? 0 : 1));
        exp_data_q.push_back(ref_mem[ea]);
        exp_tag_q.push_back(tag);
      end else if (op == 2) begin
        for (int l = 0; l < NL; l++)
          if (!bw[l]) ref_mem[ea][l*LW +: LW] = d[l*LW +: LW];
        wsched[en_cnt + 1 + (ft ? 0 : 1)] = d;
      end
      last_op   = op;
      last_addr = ea;
    end
    @(posedge clk);
    if (!stall) en_cnt++;
  endtask

  function automatic string lat_tag();
    return ft ? "R2 flow-through read" : "R1 registered read";
  endfunction

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(0, 0, 0, 1'b1, '1, a, '0, 0, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NL-1:0] bw, input logic [DW-1:0] d);
    cyc(0, 0, 0, 1'b0, bw, a, d, 0, "R3");
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 1'b1, '1, '0, '0, 0, "");
  endtask

  task automatic stall_n(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 1'b1, '1, '0, '0, 0, "R7");
  endtask

  task automatic run_phase(input bit mode);
    @(negedge clk);
    mon_on = 1'b0;
    rst_ni = 1'b0;
    clk_en_n_i = 1'b1;
    ft = mode;
    ft_mode_i = mode;
    exp_slot_q.delete();
    exp_data_q.delete();
    exp_tag_q.delete();
    wsched.delete();
    en_cnt = 0;
    last_op = 0;
    repeat (3) @(negedge clk);
    #1.5;
    check(dq_oe_o === 1'b0, "R11 bus off in reset", DW'(dq_oe_o), '0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(posedge clk);
    #1;
    check(dq_oe_o === 1'b0, "R11 bus off after reset", DW'(dq_oe_o), '0);
    mon_on = 1'b1;
    idle(2);

    // full-word writes, R3
    wr(6'd4,  2'b00, 18'h12345);
    wr(6'd5,  2'b00, 18'h0ABCD);
    wr(6'd20, 2'b00, 18'h2F0F0);
    wr(6'd8,  2'b00, 18'h11111);
    wr(6'd9,  2'b00, 18'h3C3C3);

    // R12 read-write-read with no gaps
    rd(6'd4, {lat_tag(), " R12"});
    wr(6'd10, 2'b00, 18'h15A5A);
    rd(6'd5, "R12 read after write");
    rd(6'd10, "R10 R12 read just after write");

    // R10 partial-lane writes followed at once by a read
    wr(6'd8, 2'b10, 18'h000AA);
    rd(6'd8, "R10 R6 lane0 forwarded");
    wr(6'd8, 2'b01, 18'h25500);
    wr(6'd8, 2'b10, 18'h00133);
    rd(6'd8, "R10 two pending writes merged");

    // R6 abort
    wr(6'd4, 2'b11, 18'h3FFFF);
    rd(6'd4, "R6 aborted write leaves word");

    // R5 burst write: continues with chip selects off and wr_n high, ignored
    wr(6'd12, 2'b00, 18'h0C0C0);
    cyc(0, 1, 2, 1'b1, 2'b00, 6'd40, 18'h0D0D0, 0, "R5");
    cyc(0, 1, 1, 1'b1, 2'b00, 6'd41, 18'h0E0E0, 0, "R5");
    cyc(0, 1, 3, 1'b1, 2'b00, 6'd42, 18'h0F0F0, 0, "R5");
    // R5 burst read wrapping within the 4-word group
    rd(6'd14, "R5 burst load");
    cyc(0, 1, 0, 1'b0, 2'b00, 6'd0, '0, 0, "R5 burst continue 15");
    cyc(0, 1, 1, 1'b0, 2'b00, 6'd0, '0, 0, "R5 burst wrap 12");
    cyc(0, 1, 0, 1'b0, 2'b00, 6'd0, '0, 0, "R5 burst continue 13");

    // R4 deselects on each select pin, then a continue after deselect
    cyc(0, 0, 1, 1'b0, 2'b00, 6'd20, 18'h00001, 0, "R4");
    cyc(0, 1, 0, 1'b0, 2'b00, 6'd20, 18'h00002, 0, "R4");
    cyc(0, 0, 2, 1'b0, 2'b00, 6'd20, 18'h00003, 0, "R4");
    cyc(0, 0, 3, 1'b1, 2'b00, 6'd20, 18'h00004, 0, "R4");
    rd(6'd20, "R4 deselected writes ignored");

    // R7 stalls inside a read data phase and inside a write data phase
    rd(6'd9, "R7 read held through stall");
    stall_n(2);
    rd(6'd5, "R7 read after stall");
    wr(6'd11, 2'b00, 18'h2468A);
    stall_n(2);
    rd(6'd11, "R7 write latency counts enabled edges");
    idle(1);

    // R8 output enable high over a read slot
    cyc(0, 0, 0, 1'b1, '1, 6'd4, '0, 1, "R8");
    cyc(0, 0, 1, 1'b1, '1, 6'd0, '0, 1, "R8");
    rd(6'd10, {lat_tag(), " after output enable"});
    idle(4);
    check(exp_slot_q.size() <= 0 || exp_slot_q[$] < en_cnt, "R1 R2 all reads delivered",
          DW'(exp_slot_q.size()), '0);
  endtask

  initial begin
    run_phase(1'b0);
    run_phase(1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #250000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule